// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. It runs from the conversion clock and drives the analog side: a sample-switch enable that also auto-zeroes the comparator, a comparator reset strobe, a latch strobe and ten DAC bit controls. A control bit of 1 connects its capacitor to the reference, and a 0 connects it to ground. It takes one comparator decision per bit cycle and builds the result from the most significant bit down.

The block repeats a fixed 13-cycle frame with no gaps. The frame has two sampling cycles, ten bit-trial cycles and one hold cycle. In the hold cycle the end-of-conversion flag is high and the finished word is presented in parallel. A synchronous active-high reset and a synchronous active-low clear both park the sequencer at the start of a frame with every output low. After that a new frame starts cleanly.

Top module: `sar_seq_top`

## Requirements
- R1: Frame order. The first cycle after the first clock edge that sees `rst` low and `clr_n` high is sampling cycle 0. From there, frame cycles 0-1 are sampling, cycles 2-11 are bit trials and cycle 12 is hold. Frame cycle 0 of the next frame follows cycle 12 directly, with no idle cycle.
- R2: Sampling cycles. In a sampling cycle, `sample_o` is 1, `dac_o` is all zeros, `eoc_o` is 0, and both comparator strobes are 0.
- R3: Trial bit. In frame cycle c (2 to 11) the bit under test is k = 11 - c, so bit 9 is tested first and bit 0 last. In that cycle `dac_o[k]` is 1 and every bit below k is 0.
- R4: Decision. A `cmp_i` value of 1 means the DAC level is above the sampled input. The bit under test is cleared if `cmp_i` is 1 at the clock edge that ends its trial cycle, and stays 1 if `cmp_i` is 0. Bits already decided keep their values for the rest of the conversion.
- R5: Strobes. In each trial cycle, `cmp_rst_o` is high while the clock is high, which shorts the preamplifier. `cmp_latch_o` is high while the clock is low. The decision is registered at the rising clock edge, which is also the falling edge of the latch strobe. Neither strobe is ever high outside trial cycles.
- R6: Hold cycle. In the hold cycle, `eoc_o` is 1 for exactly one cycle, `sample_o` is 0, and `dac_o` and `data_o` both carry the finished result.
- R7: Output update. `data_o` takes a new value only in the cycle where `eoc_o` rises. It keeps that value through the whole of the next frame until the next hold cycle.
- R8: Result value. With an ideal comparator (`cmp_i` = 1 when the DAC code is greater than the input code), the result equals the input code for every one of the 1024 input codes.
- R9: Clear. When `clr_n` is 0 at a clock edge, all outputs are 0 in the following cycle, including `data_o` and both strobes. After `clr_n` is released, conversion restarts at sampling cycle 0 as in R1.
- R10: Reset. While `rst` is 1 at clock edges, all outputs are 0. After `rst` is released, conversion restarts at sampling cycle 0 as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Synchronous active-low clear of the sequencer |
| cmp_i | input | 1 | Comparator decision, 1 = DAC level above input |
| sample_o | output | 1 | Sample switch enable and comparator auto-zero |
| cmp_rst_o | output | 1 | Comparator reset strobe (first half of trial cycle) |
| cmp_latch_o | output | 1 | Comparator latch strobe (second half of trial cycle) |
| dac_o | output | 10 | DAC bit controls, 1 = reference, 0 = ground |
| data_o | output | 10 | Parallel conversion result |
| eoc_o | output | 1 | End-of-conversion flag, high in the hold cycle |

## Verification
The assertions watch the frame structure on every cycle:
- hold is always followed by sampling;
- the end flag is a single pulse;
- the DAC word is zero while sampling and only one trial slot is active at a time;
- bits below the one under test stay zero;
- the output word moves only together with the end flag;
- a clear empties every output.

Only the bench scenarios can show that the value produced is right. They sweep all 1024 input codes through a model comparator, check the decided upper bits in every trial cycle and check the strobe levels in both clock halves. They also show that conversion restarts cleanly after a clear or a reset arrives in the middle of a frame.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int unsigned RES_BITS = 10;
    localparam int unsigned SAMP_CYC = 2;
    localparam int unsigned HOLD_CYC = 1;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    function automatic int unsigned frame_len(input int unsigned nbits,
                                              input int unsigned nsamp,
                                              input int unsigned nhold);
        return nsamp + nbits + nhold;
    endfunction

endpackage

// File: rtl/sar_frame_ctr.sv
module sar_frame_ctr
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS = RES_BITS,
    parameter int unsigned NSAMP = SAMP_CYC,
    parameter int unsigned NHOLD = HOLD_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    output phase_e           phase,
    output logic [NBITS-1:0] sel,
    output logic             start_trial,
    output logic             load_result,
    output logic             wrap
);

    localparam int unsigned FRAME = frame_len(NBITS, NSAMP, NHOLD);
    localparam int unsigned CW    = $clog2(FRAME);
    localparam logic [CW-1:0] LAST_SLOT   = CW'(FRAME - 1);
    localparam logic [CW-1:0] FIRST_TRIAL = CW'(NSAMP);
    localparam logic [CW-1:0] LAST_TRIAL  = CW'(NSAMP + NBITS - 1);
    localparam logic [CW-1:0] PRE_TRIAL   = CW'(NSAMP - 1);

    logic          run;
    logic [CW-1:0] cnt;

    // run drops on reset/clear; the cycle after it rises is slot 0
    always_ff @(posedge clk) begin
        if (rst || !clr_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (!run) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (cnt == LAST_SLOT) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        if (!run)                  phase = PH_IDLE;
        else if (cnt < FIRST_TRIAL) phase = PH_SAMPLE;
        else if (cnt <= LAST_TRIAL) phase = PH_TRIAL;
        else                        phase = PH_HOLD;
    end

    assign start_trial = run && (cnt == PRE_TRIAL);
    assign load_result = run && (cnt == LAST_TRIAL);
    assign wrap        = run && (cnt == LAST_SLOT);

    // one trial slot per bit, MSB occupies the first trial slot
    for (genvar k = 0; k < NBITS; k++) begin : g_sel
        localparam logic [CW-1:0] SLOT = CW'(NSAMP + NBITS - 1 - k);
        assign sel[k] = run && (cnt == SLOT);
    end

    a_r1_hold_to_sample: assert property (@(posedge clk) disable iff (rst)
        (wrap && clr_n) |=> (phase == PH_SAMPLE));

    a_r1_start_to_trial: assert property (@(posedge clk) disable iff (rst)
        (start_trial && clr_n) |=> (phase == PH_TRIAL) && sel[NBITS-1]);

    a_r3_single_slot: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRIAL) |-> ($countones(sel) == 1));

    a_r3_no_slot_outside: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_TRIAL) |-> (sel == '0));

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS = RES_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  phase_e           phase,
    input  logic [NBITS-1:0] sel,
    input  logic             start_trial,
    input  logic             wrap,
    input  logic             cmp_i,
    output logic [NBITS-1:0] dac
);

    for (genvar k = 0; k < NBITS; k++) begin : g_bit
        logic q;
        logic set_en;

        if (k == NBITS - 1) begin : g_msb
            assign set_en = start_trial;
        end else begin : g_lower
            // bit k is raised as the bit above it is being resolved
            assign set_en = sel[k+1];
        end

        always_ff @(posedge clk) begin
            if (rst || !clr_n || wrap) begin
                q <= 1'b0;
            end else if (set_en) begin
                q <= 1'b1;
            end else if (sel[k] && cmp_i) begin
                q <= 1'b0;
            end
        end

        assign dac[k] = q;
    end

    a_r2_dac_clear_sampling: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SAMPLE) |-> (dac == '0));

    a_r3_lower_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRIAL) |-> ((dac & (sel - 1'b1)) == '0));

    a_r3_trial_bit_set: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRIAL) |-> ((dac & sel) == sel));

    a_r4_decided_kept: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_TRIAL) && !sel[0] && clr_n) |=>
            ((dac & ~($past(sel) | ($past(sel) - 1'b1))) ==
             ($past(dac) & ~($past(sel) | ($past(sel) - 1'b1)))));

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
    parameter int unsigned NBITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             load_result,
    input  logic [NBITS-1:0] dac,
    input  logic [NBITS-1:0] sel,
    input  logic             cmp_i,
    output logic [NBITS-1:0] data
);

    logic [NBITS-1:0] final_word;

    // last bit resolves in the same edge that captures the word
    assign final_word = cmp_i ? (dac & ~sel) : dac;

    always_ff @(posedge clk) begin
        if (rst || !clr_n) begin
            data <= '0;
        end else if (load_result) begin
            data <= final_word;
        end
    end

endmodule

// File: rtl/sar_strobe_gen.sv
module sar_strobe_gen
    import sar_seq_pkg::*;
(
    input  logic   clk,
    input  phase_e phase,
    output logic   cmp_rst,
    output logic   cmp_latch
);

    logic in_trial;

    assign in_trial  = (phase == PH_TRIAL);
    // reset in the clock-high half, latch in the clock-low half;
    // latch falls on the rising edge that registers the decision
    assign cmp_rst   = in_trial & clk;
    assign cmp_latch = in_trial & ~clk;

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int unsigned NBITS = RES_BITS,
    parameter int unsigned NSAMP = SAMP_CYC,
    parameter int unsigned NHOLD = HOLD_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             cmp_i,
    output logic             sample_o,
    output logic             cmp_rst_o,
    output logic             cmp_latch_o,
    output logic [NBITS-1:0] dac_o,
    output logic [NBITS-1:0] data_o,
    output logic             eoc_o
);

    phase_e           phase;
    logic [NBITS-1:0] sel;
    logic             start_trial;
    logic             load_result;
    logic             wrap;

    sar_frame_ctr #(.NBITS(NBITS), .NSAMP(NSAMP), .NHOLD(NHOLD)) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .clr_n       (clr_n),
        .phase       (phase),
        .sel         (sel),
        .start_trial (start_trial),
        .load_result (load_result),
        .wrap        (wrap)
    );

    sar_bit_reg #(.NBITS(NBITS)) u_bits (
        .clk         (clk),
        .rst         (rst),
        .clr_n       (clr_n),
        .phase       (phase),
        .sel         (sel),
        .start_trial (start_trial),
        .wrap        (wrap),
        .cmp_i       (cmp_i),
        .dac         (dac_o)
    );

    sar_result_reg #(.NBITS(NBITS)) u_result (
        .clk         (clk),
        .rst         (rst),
        .clr_n       (clr_n),
        .load_result (load_result),
        .dac         (dac_o),
        .sel         (sel),
        .cmp_i       (cmp_i),
        .data        (data_o)
    );

    sar_strobe_gen u_strobe (
        .clk       (clk),
        .phase     (phase),
        .cmp_rst   (cmp_rst_o),
        .cmp_latch (cmp_latch_o)
    );

    assign sample_o = (phase == PH_SAMPLE);
    assign eoc_o    = (phase == PH_HOLD);

    always_comb begin
        if (!rst && (cmp_rst_o || cmp_latch_o)) begin
            a_r5_strobe_in_trial: assert (!sample_o && !eoc_o);
        end
    end

    a_r6_eoc_pulse: assert property (@(posedge clk) disable iff (rst)
        (eoc_o && clr_n) |=> !eoc_o);

    a_r6_hold_word_match: assert property (@(posedge clk) disable iff (rst)
        eoc_o |-> (dac_o == data_o));

    a_r7_data_moves_with_eoc: assert property (@(posedge clk) disable iff (rst)
        clr_n |=> (eoc_o || $stable(data_o)));

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (dac_o == '0) && (data_o == '0) && !sample_o && !eoc_o);

endmodule

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          clr_n;
    logic [NB-1:0] vin;
    logic          cmp;
    logic          sample_o, cmp_rst_o, cmp_latch_o, eoc_o;
    logic [NB-1:0] dac_o, data_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // ideal comparator: 1 when the DAC code is above the input code
    assign cmp = (dac_o > vin);

    sar_seq_top dut (
        .clk         (clk),
        .rst         (rst),
        .clr_n       (clr_n),
        .cmp_i       (cmp),
        .sample_o    (sample_o),
        .cmp_rst_o   (cmp_rst_o),
        .cmp_latch_o (cmp_latch_o),
        .dac_o       (dac_o),
        .data_o      (data_o),
        .eoc_o       (eoc_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_all_zero(input string tag);
        chk(tag, {sample_o, eoc_o, cmp_rst_o, cmp_latch_o, dac_o, data_o}, 32'd0);
    endtask

    // enters at rising edge + 2 of frame cycle 0, leaves at the same point of the next frame
    task automatic run_frame(input int v, input int prev);
        vin = NB'(v);
        for (int c = 0; c < 13; c++) begin
            if (c < 2) begin
                chk("R1 R2 sampling", {sample_o, eoc_o, cmp_rst_o, dac_o}, {1'b1, 1'b0, 1'b0, 10'd0});
                chk("R7 data held in sampling", data_o, prev);
            end else if (c < 12) begin
                int k = 11 - c;
                int lowm = (1 << (k + 1)) - 1;
                chk("R3 trial bit", dac_o & lowm, 1 << k);
                chk("R4 decided bits", dac_o >> (k + 1), v >> (k + 1));
                chk("R5 reset strobe high half", {cmp_rst_o, cmp_latch_o, sample_o, eoc_o}, 4'b1000);
                chk("R7 data held in trial", data_o, prev);
            end else begin
                chk("R6 hold", {eoc_o, sample_o, dac_o}, {1'b1, 1'b0, 10'(v)});
                chk("R8 result", data_o, v);
            end
            #5;
            chk("R5 latch strobe low half", {cmp_rst_o, cmp_latch_o},
                {1'b0, (c >= 2 && c < 12) ? 1'b1 : 1'b0});
            @(posedge clk);
            #2;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int prev;
        rst   = 1'b1;
        clr_n = 1'b1;
        vin   = '0;
        repeat (3) @(posedge clk);
        #2;
        chk_all_zero("R10 reset state");
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        #2;

        // exhaustive sweep over every input code
        prev = 0;
        for (int i = 0; i < 1024; i++) begin
            int v = (i * 389 + 7) % 1024;
            run_frame(v, prev);
            prev = v;
        end

        // clear in the middle of a trial sequence
        repeat (4) @(posedge clk);
        @(negedge clk) clr_n = 1'b0;
        @(posedge clk);
        #2;
        chk_all_zero("R9 clear empties outputs");
        #5;
        chk_all_zero("R9 clear low half");
        @(posedge clk);
        #2;
        chk_all_zero("R9 clear held");
        @(negedge clk) clr_n = 1'b1;
        @(posedge clk);
        #2;
        run_frame(10'h2A5, 0);
        run_frame(10'h3FF, 10'h2A5);
        run_frame(0, 10'h3FF);

        // reset in the middle of a frame
        repeat (7) @(posedge clk);
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #2;
        chk_all_zero("R10 reset mid frame");
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        #2;
        run_frame(10'h155, 0);
        run_frame(10'h200, 10'h155);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule